// File: doc/BRIEF.md
# Three-Wire Serial EEPROM Emulator

This block is a synthesizable device-side stand-in for a small serial EEPROM that is reached over a chip select, a serial clock and a data-in line. It answers on one data-out line with a separate output enable, so that the pad can be tri-stated. The storage is 64 words of 16 bits, built from registers. A fast system clock oversamples the serial pins, so the whole block runs in the system clock domain.

A command starts with a 1 bit. Then come a 2-bit opcode and a 6-bit address. Read streams words out and moves on to the next address for as long as the host keeps clocking. Single-word write, single-word erase, erase of the whole array and fill of the whole array each start a program cycle. A parameter sets the length of that cycle in system clocks, and busy/ready status is shown on data-out while it runs. Two mode commands lock and unlock programming. Programming is locked after reset.

Top module: `tw_eeprom_emu`

## Requirements
- R1: After reset the output enable is low, programming is locked and every word reads as 16'hFFFF.
- R2: While chip select is high, a command starts on the first serial-clock rise that samples data-in at 1; zeros sampled before it are ignored. The next two bits are the opcode (10 read, 01 write, 11 erase, 00 mode) and the six after that are the address, all MSB first.
- R3: After the last address bit of a read, data-out is driven with bit 15 of the addressed word. Each further serial-clock rise moves to the next lower bit.
- R4: The serial-clock rise that follows bit 0 of a read word presents bit 15 of the word at the next address, and address 63 is followed by address 0.
- R5: Write (opcode 01) takes 16 data bits MSB first after the address. When programming is unlocked, the word is stored on the 16th data bit, which is the 25th clock of the command.
- R6: Erase (opcode 11) sets the addressed word to 16'hFFFF. The mode command with address bits [5:4]=10 sets every word to 16'hFFFF. Both take effect on the last address bit.
- R7: The mode command with address bits [5:4]=01 takes 16 data bits and stores them in every word.
- R8: The mode command with address bits [5:4]=11 unlocks programming and [5:4]=00 locks it. Address bits [3:0] of mode commands are don't-care.
- R9: While programming is locked, write, erase, erase-all and write-all leave the storage unchanged and start no program cycle.
- R10: A program cycle lasts BUSY_CYCLES system clocks. While chip select is high after the command, data-out is driven 0 while busy and 1 once ready.
- R11: The output enable is low while chip select is low, and it stays low after a lock or unlock command.
- R12: Lowering chip select before a command is complete discards it. Lowering it after a program cycle has started does not stop that cycle.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock, much faster than the serial clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cs_i | input | 1 | Chip select, active high, asynchronous to clk |
| sck_i | input | 1 | Serial clock, asynchronous to clk |
| di_i | input | 1 | Serial data in, sampled on the serial-clock rise |
| do_o | output | 1 | Serial data out: read data or busy/ready status |
| do_oe_o | output | 1 | Output enable for do_o; low means high impedance |

## Verification
The assertions assume that the serial pins change slowly compared with the system clock. Each serial-clock level and each data-in value must last several system clocks, so that the two-flop synchronizers deliver one clean rise per serial bit. They also assume that no new command is started while a program cycle is running. The stimulus holds every level for eight system clocks and changes data-in only while the serial clock is low. After each program command it waits longer than BUSY_CYCLES before it raises chip select for a new command.

// File: rtl/tw_eeprom_pkg.sv
// Package: shared encodings for the three-wire EEPROM emulator.
// Assumes: opcode and mode values are decoded from the serial frame as sent.
package tw_eeprom_pkg;

    // Two-bit opcode that follows the start bit.
    typedef enum logic [1:0] {
        OP_MODE  = 2'b00,
        OP_WRITE = 2'b01,
        OP_READ  = 2'b10,
        OP_ERASE = 2'b11
    } op_e;

    // Sub-command carried in the top two address bits of a mode command.
    typedef enum logic [1:0] {
        MD_LOCK   = 2'b00,
        MD_FILL   = 2'b01,
        MD_CLEAR  = 2'b10,
        MD_UNLOCK = 2'b11
    } mode_e;

    // Command sequencer states.
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CMD,
        ST_DATA,
        ST_READ,
        ST_DONE
    } state_e;

endpackage

// File: rtl/tw_sync.sv
// Module: tw_sync
// Brings W asynchronous single-bit inputs into the clk domain through two
// flops each. Assumes every input level lasts several clk periods.
module tw_sync #(
    parameter int W = 3
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] async_i,
    output logic [W-1:0] sync_o
);
    for (genvar g = 0; g < W; g++) begin : g_bit
        logic meta_q;
        logic sync_q;
        // Two-stage synchronizer for one bit.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                meta_q <= 1'b0;
                sync_q <= 1'b0;
            end else begin
                meta_q <= async_i[g];
                sync_q <= meta_q;
            end
        end
        assign sync_o[g] = sync_q;
    end
endmodule

// File: rtl/tw_busy_timer.sv
// Module: tw_busy_timer
// Counts the program cycle length in system clocks. A start pulse loads the
// count and busy stays high until it runs out. Assumes start arrives only
// while idle.
module tw_busy_timer #(
    parameter int CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start_i,
    output logic busy_o
);
    localparam int CW = $clog2(CYCLES + 1);
    localparam logic [CW-1:0] LOAD = CW'(CYCLES);

    logic [CW-1:0] cnt_q;

    // Load on start, count down to zero.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else if (start_i) begin
            cnt_q <= LOAD;
        end else if (cnt_q != '0) begin
            cnt_q <= cnt_q - 1'b1;
        end
    end

    assign busy_o = (cnt_q != '0);
endmodule

// File: rtl/tw_mem_array.sv
// Module: tw_mem_array
// Register storage of 2**AW words. It has one asynchronous read port and a
// write port that updates either one word or all words. Reset loads the
// erased value (all ones). Assumes we_one and we_all are not both high.
module tw_mem_array #(
    parameter int AW = 6,
    parameter int DW = 16
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_one_i,
    input  logic          we_all_i,
    input  logic [AW-1:0] waddr_i,
    input  logic [DW-1:0] wdata_i,
    input  logic [AW-1:0] raddr_i,
    output logic [DW-1:0] rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] words [DEPTH];

    for (genvar g = 0; g < DEPTH; g++) begin : g_word
        // Update one storage word on a matching single or broadcast write.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                words[g] <= '1;
            end else if (we_all_i || (we_one_i && (waddr_i == AW'(g)))) begin
                words[g] <= wdata_i;
            end
        end
    end

    assign rdata_o = words[raddr_i];
endmodule

// File: rtl/tw_eeprom_emu.sv
// Module: tw_eeprom_emu (top)
// Device-side model of a three-wire serial EEPROM. It frames commands
// (start bit, opcode, address), streams read data with address increment,
// runs program cycles through a busy timer and reports status on data-out.
// Assumes the serial pins are much slower than clk; di_i is taken on the
// synchronized serial-clock rise.
module tw_eeprom_emu
    import tw_eeprom_pkg::*;
#(
    parameter int ADDR_W      = 6,
    parameter int DATA_W      = 16,
    parameter int BUSY_CYCLES = 200
) (
    input  logic clk,
    input  logic rst_n,
    input  logic cs_i,
    input  logic sck_i,
    input  logic di_i,
    output logic do_o,
    output logic do_oe_o
);
    localparam int FRAME_W = 2 + ADDR_W;
    localparam int CNT_MAX = (DATA_W > FRAME_W) ? DATA_W : FRAME_W;
    localparam int CNT_W   = $clog2(CNT_MAX);
    localparam logic [CNT_W-1:0] FRAME_LAST = CNT_W'(FRAME_W - 1);
    localparam logic [CNT_W-1:0] DATA_LAST  = CNT_W'(DATA_W - 1);

    logic cs_s, sck_s, di_s, sck_d;
    logic sck_rise;
    logic busy;

    state_e               state;
    logic [CNT_W-1:0]     bit_cnt;
    logic [FRAME_W-2:0]   cmd_sh;
    logic [DATA_W-2:0]    data_sh;
    op_e                  op_r;
    logic [ADDR_W-1:0]    addr_r;
    logic [ADDR_W-1:0]    rd_addr;
    logic                 wr_en;
    logic                 status_flag;
    logic                 pstart_r, pone_r, pall_r;
    logic [ADDR_W-1:0]    paddr_r;
    logic [DATA_W-1:0]    pdata_r;
    logic [DATA_W-1:0]    rdata;

    logic [FRAME_W-1:0]   frame_nx;
    logic [DATA_W-1:0]    word_nx;
    op_e                  op_nx;
    mode_e                md_nx;
    logic [ADDR_W-1:0]    addr_nx;
    logic [CNT_W-1:0]     rd_idx;

    tw_sync #(.W(3)) u_sync (
        .clk     (clk),
        .rst_n   (rst_n),
        .async_i ({cs_i, sck_i, di_i}),
        .sync_o  ({cs_s, sck_s, di_s})
    );

    // Delay the synchronized serial clock for rise detection.
    always_ff @(posedge clk) begin
        if (!rst_n) sck_d <= 1'b0;
        else        sck_d <= sck_s;
    end
    assign sck_rise = sck_s & ~sck_d;

    assign frame_nx = {cmd_sh, di_s};
    assign word_nx  = {data_sh, di_s};
    assign op_nx    = op_e'(frame_nx[FRAME_W-1 -: 2]);
    assign md_nx    = mode_e'(frame_nx[ADDR_W-1 -: 2]);
    assign addr_nx  = frame_nx[ADDR_W-1:0];
    assign rd_idx   = DATA_LAST - bit_cnt;

    // Command sequencer: framing, decode, data capture, program requests.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state       <= ST_IDLE;
            bit_cnt     <= '0;
            cmd_sh      <= '0;
            data_sh     <= '0;
            op_r        <= OP_MODE;
            addr_r      <= '0;
            rd_addr     <= '0;
            wr_en       <= 1'b0;
            status_flag <= 1'b0;
            pstart_r    <= 1'b0;
            pone_r      <= 1'b0;
            pall_r      <= 1'b0;
            paddr_r     <= '0;
            pdata_r     <= '0;
        end else begin
            pstart_r <= 1'b0;
            pone_r   <= 1'b0;
            pall_r   <= 1'b0;
            if (!cs_s) begin
                state   <= ST_IDLE;
                bit_cnt <= '0;
            end else if (sck_rise) begin
                unique case (state)
                    ST_IDLE: begin
                        if (di_s && !busy) begin
                            state       <= ST_CMD;
                            bit_cnt     <= '0;
                            status_flag <= 1'b0;
                        end
                    end
                    ST_CMD: begin
                        cmd_sh  <= frame_nx[FRAME_W-2:0];
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == FRAME_LAST) begin
                            bit_cnt <= '0;
                            op_r    <= op_nx;
                            addr_r  <= addr_nx;
                            state   <= ST_DONE;
                            unique case (op_nx)
                                OP_READ: begin
                                    state   <= ST_READ;
                                    rd_addr <= addr_nx;
                                end
                                OP_WRITE: state <= ST_DATA;
                                OP_ERASE: begin
                                    if (wr_en) begin
                                        pstart_r    <= 1'b1;
                                        pone_r      <= 1'b1;
                                        paddr_r     <= addr_nx;
                                        pdata_r     <= '1;
                                        status_flag <= 1'b1;
                                    end
                                end
                                default: begin
                                    unique case (md_nx)
                                        MD_UNLOCK: wr_en <= 1'b1;
                                        MD_LOCK:   wr_en <= 1'b0;
                                        MD_FILL:   state <= ST_DATA;
                                        default: begin
                                            if (wr_en) begin
                                                pstart_r    <= 1'b1;
                                                pall_r      <= 1'b1;
                                                pdata_r     <= '1;
                                                status_flag <= 1'b1;
                                            end
                                        end
                                    endcase
                                end
                            endcase
                        end
                    end
                    ST_DATA: begin
                        data_sh <= word_nx[DATA_W-2:0];
                        bit_cnt <= bit_cnt + 1'b1;
                        if (bit_cnt == DATA_LAST) begin
                            bit_cnt <= '0;
                            state   <= ST_DONE;
                            if (wr_en) begin
                                pstart_r    <= 1'b1;
                                pone_r      <= (op_r == OP_WRITE);
                                pall_r      <= (op_r != OP_WRITE);
                                paddr_r     <= addr_r;
                                pdata_r     <= word_nx;
                                status_flag <= 1'b1;
                            end
                        end
                    end
                    ST_READ: begin
                        if (bit_cnt == DATA_LAST) begin
                            bit_cnt <= '0;
                            rd_addr <= rd_addr + 1'b1;
                        end else begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end
                    end
                    default: ;
                endcase
            end
        end
    end

    tw_mem_array #(.AW(ADDR_W), .DW(DATA_W)) u_mem (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_one_i (pone_r),
        .we_all_i (pall_r),
        .waddr_i  (paddr_r),
        .wdata_i  (pdata_r),
        .raddr_i  (rd_addr),
        .rdata_o  (rdata)
    );

    tw_busy_timer #(.CYCLES(BUSY_CYCLES)) u_busy (
        .clk     (clk),
        .rst_n   (rst_n),
        .start_i (pstart_r),
        .busy_o  (busy)
    );

    // Output register: read bit, busy/ready status, or released line.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            do_oe_o <= 1'b0;
            do_o    <= 1'b1;
        end else if (cs_s && (state == ST_READ)) begin
            do_oe_o <= 1'b1;
            do_o    <= rdata[rd_idx];
        end else if (cs_s && status_flag && ((state == ST_IDLE) || (state == ST_DONE))) begin
            do_oe_o <= 1'b1;
            do_o    <= !(busy || pstart_r);
        end else begin
            do_oe_o <= 1'b0;
            do_o    <= 1'b1;
        end
    end
endmodule

// File: rtl/tw_eeprom_chk.sv
// Module: tw_eeprom_chk
// Assertion checker attached to tw_eeprom_emu by bind. It watches the
// synchronized chip select, the lock state, program requests, the busy timer
// and the data-out pins. Assumes the serial pins are slower than clk.
module tw_eeprom_chk (
    input logic clk,
    input logic rst_n,
    input logic cs_s,
    input logic wr_en,
    input logic prog_start,
    input logic busy,
    input logic do_o,
    input logic do_oe_o
);
    AST_OE_OFF_CS_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        !cs_s |=> !do_oe_o); // R11

    AST_LOCKED_NO_PROG: assert property (@(posedge clk) disable iff (!rst_n)
        !wr_en |=> !prog_start); // R9

    AST_BUSY_FOLLOWS_START: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |=> busy); // R10

    AST_START_WHEN_READY: assert property (@(posedge clk) disable iff (!rst_n)
        prog_start |-> !busy); // R10

    AST_BUSY_DRIVES_LOW: assert property (@(posedge clk) disable iff (!rst_n)
        (busy && do_oe_o) |-> !do_o); // R10
endmodule

bind tw_eeprom_emu tw_eeprom_chk u_chk (
    .clk        (clk),
    .rst_n      (rst_n),
    .cs_s       (cs_s),
    .wr_en      (wr_en),
    .prog_start (pstart_r),
    .busy       (busy),
    .do_o       (do_o),
    .do_oe_o    (do_oe_o)
);

// File: tb/tb_tw_eeprom_emu.sv
`timescale 1ns/1ps
module tb_tw_eeprom_emu;
    localparam int BUSY = 200;
    localparam int HALF = 8;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cs = 1'b0, sck = 1'b0, di = 1'b0;
    logic do_w, oe_w;

    int checks = 0;
    int errors = 0;
    bit done = 0;

    typedef struct {
        logic  v;
        logic  oe;
        string tag;
    } exp_t;
    exp_t exp_q[$];
    event smp;

    logic [15:0] model [64];

    always #4 clk = ~clk;

    tw_eeprom_emu #(.ADDR_W(6), .DATA_W(16), .BUSY_CYCLES(BUSY)) dut (
        .clk(clk), .rst_n(rst_n), .cs_i(cs), .sck_i(sck), .di_i(di),
        .do_o(do_w), .do_oe_o(oe_w)
    );

    // Monitor: pop expected items and compare against the pins.
    initial forever begin
        @(smp);
        while (exp_q.size() > 0) begin
            exp_t e;
            e = exp_q.pop_front();
            checks++;
            if (oe_w !== e.oe || (e.oe && do_w !== e.v)) begin
                errors++;
                $display("FAIL %s: do=%b oe=%b expected do=%b oe=%b",
                         e.tag, do_w, oe_w, e.v, e.oe);
            end
        end
    end

    task automatic expect_do(input logic v, input logic oe, input string tag);
        @(negedge clk);
        exp_q.push_back('{v: v, oe: oe, tag: tag});
        -> smp;
        #1;
    endtask

    task automatic bit_out(input logic b);
        di = b;
        repeat (HALF) @(posedge clk);
        sck = 1'b1;
        repeat (HALF) @(posedge clk);
        sck = 1'b0;
    endtask

    task automatic cs_on();
        cs = 1'b1;
        repeat (HALF) @(posedge clk);
    endtask

    task automatic cs_off();
        sck = 1'b0;
        cs = 1'b0;
        repeat (HALF) @(posedge clk);
    endtask

    task automatic send_cmd(input logic [1:0] op, input logic [5:0] a);
        bit_out(1'b1);
        for (int i = 1; i >= 0; i--) bit_out(op[i]);
        for (int i = 5; i >= 0; i--) bit_out(a[i]);
    endtask

    task automatic send_word(input logic [15:0] d);
        for (int i = 15; i >= 0; i--) bit_out(d[i]);
    endtask

    task automatic wait_prog();
        repeat (BUSY + 20) @(posedge clk);
    endtask

    // Read n words from a with streaming; compares to the bench model.
    task automatic read_words(input logic [5:0] a, input int n, input int lead, input string tag);
        logic [5:0] ad;
        ad = a;
        cs_on();
        for (int z = 0; z < lead; z++) bit_out(1'b0);
        send_cmd(2'b10, a);
        for (int w = 0; w < n; w++) begin
            for (int i = 15; i >= 0; i--) begin
                if (!(w == 0 && i == 15)) bit_out(1'b0);
                expect_do(model[ad][i], 1'b1, tag);
            end
            ad = ad + 6'd1;
        end
        cs_off();
    endtask

    task automatic do_mode(input logic [1:0] md);
        cs_on();
        send_cmd(2'b00, {md, 4'b1010});
        cs_off();
    endtask

    task automatic do_write(input logic [5:0] a, input logic [15:0] d);
        cs_on();
        send_cmd(2'b01, a);
        send_word(d);
        cs_off();
        wait_prog();
    endtask

    // Watchdog: a hung run counts as a failure and still reports.
    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            errors++;
            $display("FAIL watchdog: run did not complete");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        repeat (5) @(posedge clk);
        rst_n = 1'b1;
        repeat (5) @(posedge clk);

        // R1: reset state
        expect_do(1'b1, 1'b0, "R1 oe after reset");
        read_words(6'd5, 1, 0, "R1 R3 erased word after reset");

        // R9: write ignored while locked (power-up lock)
        cs_on();
        send_cmd(2'b01, 6'd3);
        send_word(16'h1234);
        repeat (4) @(posedge clk);
        expect_do(1'b1, 1'b0, "R9 no status when locked");
        cs_off();
        wait_prog();
        read_words(6'd3, 1, 0, "R9 locked write ignored");

        // R8 R11: unlock, line stays released
        cs_on();
        send_cmd(2'b00, 6'b110101);
        repeat (4) @(posedge clk);
        expect_do(1'b1, 1'b0, "R11 oe after unlock");
        cs_off();
        expect_do(1'b1, 1'b0, "R11 oe with cs low");

        // R5 R10: write with status while chip select stays high
        cs_on();
        send_cmd(2'b01, 6'd3);
        send_word(16'hA5C3);
        model[3] = 16'hA5C3;
        expect_do(1'b0, 1'b1, "R10 busy drives low");
        wait_prog();
        expect_do(1'b1, 1'b1, "R10 ready drives high");
        cs_off();

        do_write(6'd4, 16'h0F0F);  model[4]  = 16'h0F0F;
        do_write(6'd63, 16'h8001); model[63] = 16'h8001;
        do_write(6'd0, 16'h7E11);  model[0]  = 16'h7E11;

        // R2 R3 R4 R5: streaming read with leading zeros, and wrap
        read_words(6'd3, 2, 2, "R2 R4 R5 stream from 3");
        read_words(6'd63, 2, 0, "R4 wrap 63 to 0");

        // R6: single erase
        cs_on();
        send_cmd(2'b11, 6'd4);
        model[4] = 16'hFFFF;
        expect_do(1'b0, 1'b1, "R6 R10 erase busy");
        cs_off();
        wait_prog();
        read_words(6'd4, 1, 0, "R6 erased word");

        // R12: aborted write leaves word unchanged
        cs_on();
        send_cmd(2'b01, 6'd10);
        for (int i = 0; i < 10; i++) bit_out(1'b0);
        cs_off();
        wait_prog();
        read_words(6'd10, 1, 0, "R12 aborted write");

        // R12: chip select low does not stop a started program cycle
        cs_on();
        send_cmd(2'b01, 6'd11);
        send_word(16'hBEEF);
        model[11] = 16'hBEEF;
        cs_off();
        wait_prog();
        cs_on();
        expect_do(1'b1, 1'b1, "R12 R10 ready after cs drop");
        cs_off();
        read_words(6'd11, 1, 0, "R12 program completed");

        // R8 R9: lock again, write ignored
        do_mode(2'b00);
        do_write(6'd12, 16'h0000);
        read_words(6'd12, 1, 0, "R8 R9 relocked write ignored");
        cs_on();
        send_cmd(2'b11, 6'd3);
        cs_off();
        wait_prog();
        read_words(6'd3, 1, 0, "R9 locked erase ignored");

        // R7: write-all
        do_mode(2'b11);
        cs_on();
        send_cmd(2'b00, 6'b010011);
        send_word(16'h5A5A);
        cs_off();
        wait_prog();
        for (int i = 0; i < 64; i++) model[i] = 16'h5A5A;
        read_words(6'd0, 1, 0, "R7 fill word 0");
        read_words(6'd33, 1, 0, "R7 fill word 33");

        // R6: erase-all
        cs_on();
        send_cmd(2'b00, 6'b100110);
        expect_do(1'b0, 1'b1, "R6 R10 erase-all busy");
        cs_off();
        wait_prog();
        for (int i = 0; i < 64; i++) model[i] = 16'hFFFF;
        read_words(6'd7, 1, 0, "R6 erase-all word 7");

        done = 1;
        repeat (4) @(posedge clk);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule